// File: doc/BRIEF.md
# Framed SPI Exchange Master

This block is an SPI master that carries one variable-length message per transaction to a peer processor over a full-duplex link. Every transaction begins with a two-byte header. The local side and the peer shift their headers out at the same moment. Each header carries a command and an 11-bit length. After the header, the block runs a payload phase that is long enough for both messages and is then padded. Chip select stays low for the whole transaction.

The peer drives two handshake inputs. A rising edge on `ctsIn` arms the block for exactly one transaction. A high level on `rtsIn` asks the block to collect a message from the peer. The local user supplies a command, a length and a payload byte stream, pulled with `txPop`. In return it receives the peer's decoded header and the peer's payload bytes. When nothing is waiting to be sent and the peer holds `rtsIn` high, the block runs an empty poll transaction. A rising edge on `rtsIn` while the block is armed makes it issue a one-byte link reset instead.

Top module: `frame_link_master`

## Requirements
- R1: Header byte 0 on MOSI is `{cmd[4:0], len[10:8]}`. Header byte 1 is `len[7:0]`. Both use the local command and length of the transaction.
- R2: The two header bytes received on MISO are decoded with the R1 layout. The decoded command and length appear on `rxCmd`/`rxLen` with a one-cycle `rxHdrValid` pulse.
- R3: The payload phase length starts from the larger of the local length and the decoded peer length.
- R4: A payload length below 6 becomes 6. Any other length n is raised to the smallest value m ≥ n for which m+2 is a multiple of 4.
- R5: `csN` stays low from the start of header byte 0 to the end of the last payload byte. After that, `csN` rises, and `done` pulses for one cycle in the first cycle that `csN` is high.
- R6: A transaction starts only while `enable` is high and a rising edge of `ctsIn` has been latched. Starting a transaction consumes the latch. Requests made without a fresh edge wait.
- R7: If no send is requested and `rtsIn` is high, the block runs a poll transaction with command 0 and length 0.
- R8: A decoded peer command of 0 produces no `rxHdrValid` pulse and no `rxValid` bytes. The payload phase is still sized with the peer length.
- R9: The bus runs SPI mode 0: `sclk` idles low, MOSI holds steady while `sclk` is high, MISO is sampled on the rising edge, and bytes go MSB first.
- R10: Payload positions at or beyond the local length are sent as 0x00 without pulling `txData`. Exactly `len` bytes are pulled with `txPop`. Received positions at or beyond the peer length are dropped.
- R11: Bit 4 of the outgoing command marks "no incoming". When it is set, the received header is treated as command 0 and length 0.
- R12: A rising edge of `rtsIn` while the block is idle, enabled and has a latched CTS edge sends a single 0x00 byte with `csN` low, then releases `csN` and pulses `done`.
- R13: When the block is able to start, the link reset has priority over a pending send, and a pending send has priority over a poll. A send start is acknowledged by a one-cycle `sendAck` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows transactions to start |
| ctsIn | input | 1 | Peer clear-to-send; a rising edge arms one transaction |
| rtsIn | input | 1 | Peer request-to-send level |
| sendValid | input | 1 | Local message waiting |
| sendCmd | input | 5 | Local command; bit 4 means no incoming message |
| sendLen | input | 11 | Local payload length in bytes |
| sendAck | output | 1 | Pulse when a send transaction starts |
| txData | input | 8 | Next local payload byte |
| txPop | output | 1 | `txData` is taken at this clock edge |
| rxCmd | output | 5 | Decoded peer command |
| rxLen | output | 11 | Decoded peer length |
| rxHdrValid | output | 1 | Pulse: `rxCmd`/`rxLen` are valid |
| rxData | output | 8 | Received peer payload byte |
| rxValid | output | 1 | Pulse: `rxData` is valid |
| done | output | 1 | Pulse after chip select is released |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| csN | output | 1 | Active-low chip select |

## Verification
`done` and the rise of `csN` fall in the same cycle. `rxHdrValid` follows the last header bit by one clock, and each `rxValid` pulse follows the last bit of its payload byte by one clock. `txPop` is combinational and marks the edge at which `txData` is loaded. The CTS and RTS inputs pass through two synchronizer flops, so a start comes three to four cycles after the edge. The bench therefore samples every output on the falling clock edge and accumulates the events over a whole transaction. It compares totals and byte contents only after `done`, and it relies on `txPop`, which it counts at the rising edge, as the sole cycle-exact strobe.

// File: rtl/frame_link_pkg.sv
package frame_link_pkg;

  typedef enum logic [1:0] {
    SRC_HDR0 = 2'd0,
    SRC_HDR1 = 2'd1,
    SRC_PAY  = 2'd2,
    SRC_ZERO = 2'd3
  } byteSrc_e;

  typedef struct packed {
    logic     kick;
    byteSrc_e src;
    logic     latchLocal;
    logic     pollTx;
    logic     capHdr0;
    logic     capHdr1;
    logic     payAdv;
  } dpStrobe_t;

  typedef struct packed {
    logic byteDone;
    logic payLast;
  } dpStatus_t;

  function automatic logic [15:0] padLen(input logic [15:0] n);
    if (n < 16'd6) return 16'd6;
    return ((n + 16'd5) & ~16'd3) - 16'd2;
  endfunction

endpackage

// File: rtl/frame_link_dp.sv
module frame_link_dp
  import frame_link_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int CMD_W    = 5,
  parameter int LEN_W    = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  output dpStatus_t        status,
  input  logic [CMD_W-1:0] sendCmd,
  input  logic [LEN_W-1:0] sendLen,
  input  logic [7:0]       txData,
  output logic             txPop,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic [7:0]       rxData,
  output logic             rxValid,
  output logic [CMD_W-1:0] rxCmd,
  output logic [LEN_W-1:0] rxLen,
  output logic             rxHdrValid
);

  localparam int TOT_W = LEN_W + 1;
  localparam int HI_W  = LEN_W - 8;
  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CMD_W-1:0] localCmd, curCmd, peerCmd, decCmd;
  logic [LEN_W-1:0] localLen, curLen, peerLen, decLen, maxLen;
  logic [7:0]       hdr0, txByte, payByte, shiftReg;
  logic [TOT_W-1:0] totalLen, payIdx, kickIdx;
  logic             forced, active, sampled, byteDone;
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;

  // local header values, usable in the same cycle they are latched
  assign curCmd = strobe.latchLocal ? (strobe.pollTx ? '0 : sendCmd) : localCmd;
  assign curLen = strobe.latchLocal ? (strobe.pollTx ? '0 : sendLen) : localLen;

  assign kickIdx = strobe.capHdr1 ? '0 : (strobe.payAdv ? payIdx + TOT_W'(1) : payIdx);
  assign payByte = (kickIdx < TOT_W'(localLen)) ? txData : 8'h00;
  assign txPop   = strobe.kick && (strobe.src == SRC_PAY) && (kickIdx < TOT_W'(localLen));

  always_comb begin
    case (strobe.src)
      SRC_HDR0: txByte = {curCmd, curLen[LEN_W-1:8]};
      SRC_HDR1: txByte = localLen[7:0];
      SRC_PAY:  txByte = payByte;
      default:  txByte = 8'h00;
    endcase
  end

  // header decode of the peer's bytes
  assign forced = localCmd[CMD_W-1];
  assign decCmd = forced ? '0 : hdr0[7 -: CMD_W];
  assign decLen = forced ? '0 : {hdr0[HI_W-1:0], shiftReg};
  assign maxLen = (decLen > localLen) ? decLen : localLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      localCmd   <= '0;
      localLen   <= '0;
      hdr0       <= '0;
      peerCmd    <= '0;
      peerLen    <= '0;
      totalLen   <= TOT_W'(6);
      payIdx     <= '0;
      rxHdrValid <= 1'b0;
      rxValid    <= 1'b0;
      rxData     <= '0;
    end else begin
      rxHdrValid <= 1'b0;
      rxValid    <= 1'b0;
      if (strobe.latchLocal) begin
        localCmd <= curCmd;
        localLen <= curLen;
      end
      if (strobe.capHdr0) hdr0 <= shiftReg;
      if (strobe.capHdr1) begin
        peerCmd    <= decCmd;
        peerLen    <= decLen;
        totalLen   <= TOT_W'(padLen(16'(maxLen)));
        payIdx     <= '0;
        rxHdrValid <= (decCmd != '0);
      end
      if (strobe.payAdv) begin
        payIdx  <= payIdx + TOT_W'(1);
        rxValid <= (peerCmd != '0) && (payIdx < TOT_W'(peerLen));
        rxData  <= shiftReg;
      end
    end
  end

  // mode-0 byte shifter: drive on falling edge, sample on rising edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      sclk     <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      sampled  <= 1'b0;
      shiftReg <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (strobe.kick) begin
        shiftReg <= txByte;
        active   <= 1'b1;
        sclk     <= 1'b0;
        divCnt   <= '0;
        bitCnt   <= '0;
      end else if (active) begin
        if (divCnt == DIV_W'(DIV_HALF - 1)) begin
          divCnt <= '0;
          if (!sclk) begin
            sclk    <= 1'b1;
            sampled <= miso;
          end else begin
            sclk     <= 1'b0;
            shiftReg <= {shiftReg[6:0], sampled};
            bitCnt   <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              active   <= 1'b0;
              byteDone <= 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  assign mosi            = shiftReg[7];
  assign rxCmd           = peerCmd;
  assign rxLen           = peerLen;
  assign status.byteDone = byteDone;
  assign status.payLast  = (payIdx == totalLen - TOT_W'(1));

  p_pad_rule_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capHdr1 |=> (totalLen >= TOT_W'(6)) && (totalLen[1:0] == 2'b10));

  p_covers_both_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capHdr1 |=> (totalLen >= TOT_W'(localLen)) && (totalLen >= TOT_W'(peerLen)));

  p_no_incoming_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capHdr1 && localCmd[CMD_W-1]) |=> (peerCmd == '0) && (peerLen == '0) && !rxHdrValid);

  p_mosi_steady_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/frame_link_ctrl.sv
module frame_link_ctrl
  import frame_link_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      ctsIn,
  input  logic      rtsIn,
  input  logic      sendValid,
  output logic      sendAck,
  output dpStrobe_t strobe,
  input  dpStatus_t status,
  output logic      csN,
  output logic      done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LINKRST, ST_HDR0, ST_HDR1, ST_PAY, ST_FIN
  } state_e;

  state_e     state, stateNext;
  logic [1:0] ctsSync, rtsSync;
  logic       ctsPrev, rtsPrev, ctsLatched, ctsRise, rtsRise, startNow;

  assign ctsRise = ctsSync[1] && !ctsPrev;
  assign rtsRise = rtsSync[1] && !rtsPrev;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    sendAck   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (enable && ctsLatched) begin
          if (rtsRise) begin
            strobe.kick = 1'b1;
            strobe.src  = SRC_ZERO;
            stateNext   = ST_LINKRST;
          end else if (sendValid) begin
            strobe.latchLocal = 1'b1;
            strobe.kick       = 1'b1;
            strobe.src        = SRC_HDR0;
            sendAck           = 1'b1;
            stateNext         = ST_HDR0;
          end else if (rtsSync[1]) begin
            strobe.latchLocal = 1'b1;
            strobe.pollTx     = 1'b1;
            strobe.kick       = 1'b1;
            strobe.src        = SRC_HDR0;
            stateNext         = ST_HDR0;
          end
        end
      end
      ST_LINKRST: if (status.byteDone) stateNext = ST_FIN;
      ST_HDR0: begin
        if (status.byteDone) begin
          strobe.capHdr0 = 1'b1;
          strobe.kick    = 1'b1;
          strobe.src     = SRC_HDR1;
          stateNext      = ST_HDR1;
        end
      end
      ST_HDR1: begin
        if (status.byteDone) begin
          strobe.capHdr1 = 1'b1;
          strobe.kick    = 1'b1;
          strobe.src     = SRC_PAY;
          stateNext      = ST_PAY;
        end
      end
      ST_PAY: begin
        if (status.byteDone) begin
          strobe.payAdv = 1'b1;
          if (status.payLast) begin
            stateNext = ST_FIN;
          end else begin
            strobe.kick = 1'b1;
            strobe.src  = SRC_PAY;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign startNow = (state == ST_IDLE) && (stateNext != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      ctsSync    <= '0;
      rtsSync    <= '0;
      ctsPrev    <= 1'b0;
      rtsPrev    <= 1'b0;
      ctsLatched <= 1'b0;
    end else begin
      state   <= stateNext;
      ctsSync <= {ctsSync[0], ctsIn};
      rtsSync <= {rtsSync[0], rtsIn};
      ctsPrev <= ctsSync[1];
      rtsPrev <= rtsSync[1];
      if (ctsRise)       ctsLatched <= 1'b1;
      else if (startNow) ctsLatched <= 1'b0;
    end
  end

  assign csN  = (state == ST_IDLE) || (state == ST_FIN);
  assign done = (state == ST_FIN);

  p_start_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $past(enable) && $past(ctsLatched));

  p_cts_consumed_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(csN) && !$past(ctsRise)) |-> !ctsLatched);

  p_done_on_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> csN && !$past(csN));

endmodule

// File: rtl/frame_link_master.sv
module frame_link_master
  import frame_link_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int CMD_W    = 5,
  parameter int LEN_W    = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             ctsIn,
  input  logic             rtsIn,
  input  logic             sendValid,
  input  logic [CMD_W-1:0] sendCmd,
  input  logic [LEN_W-1:0] sendLen,
  output logic             sendAck,
  input  logic [7:0]       txData,
  output logic             txPop,
  output logic [CMD_W-1:0] rxCmd,
  output logic [LEN_W-1:0] rxLen,
  output logic             rxHdrValid,
  output logic [7:0]       rxData,
  output logic             rxValid,
  output logic             done,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             csN
);

  dpStrobe_t strobe;
  dpStatus_t status;

  frame_link_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .ctsIn     (ctsIn),
    .rtsIn     (rtsIn),
    .sendValid (sendValid),
    .sendAck   (sendAck),
    .strobe    (strobe),
    .status    (status),
    .csN       (csN),
    .done      (done)
  );

  frame_link_dp #(
    .DIV_HALF (DIV_HALF),
    .CMD_W    (CMD_W),
    .LEN_W    (LEN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .status     (status),
    .sendCmd    (sendCmd),
    .sendLen    (sendLen),
    .txData     (txData),
    .txPop      (txPop),
    .miso       (miso),
    .sclk       (sclk),
    .mosi       (mosi),
    .rxData     (rxData),
    .rxValid    (rxValid),
    .rxCmd      (rxCmd),
    .rxLen      (rxLen),
    .rxHdrValid (rxHdrValid)
  );

  p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  p_zero_cmd_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxHdrValid |-> (rxCmd != '0));

endmodule

// File: tb/frame_link_master_test.sv
`timescale 1ns/1ps
module frame_link_master_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, ctsIn = 1'b0, rtsIn = 1'b0, sendValid = 1'b0;
  logic [4:0] sendCmd = '0;
  logic [10:0] sendLen = '0;
  logic sendAck, txPop, rxHdrValid, rxValid, done, sclk, mosi, miso, csN;
  logic [7:0] txData, rxData;
  logic [4:0] rxCmd;
  logic [10:0] rxLen;

  always #10 clk = ~clk;

  int checkCnt = 0, passCnt = 0, cyc = 0;
  int doneTot = 0, csFallTot = 0, csRiseTot = 0, hdrTot = 0, rxTot = 0, rxBase = 0;
  int popTot = 0, popBase = 0;
  logic csPrev = 1'b1;
  logic [4:0] lastCmd = '0;
  logic [10:0] lastLen = '0;
  logic [7:0] rxGot [0:63];

  // peer model state
  logic [4:0] pcT = '0;
  logic [10:0] plT = '0;
  int pRxTot = 0, pBase = 0, pBit = 0, pIdx;
  logic [7:0] pShift = '0, curOut;
  logic [7:0] peerRx [0:63];

  function automatic logic [7:0] localPat(input int k);
    return 8'((k * 13 + 7) & 255);
  endfunction

  function automatic logic [7:0] peerPat(input int k);
    return 8'((k * 29 + 91) & 255);
  endfunction

  function automatic int padRef(input int m);
    int t;
    t = m;
    if (t < 6) t = 6;
    while (((t + 2) % 4) != 0) t = t + 1;
    return t;
  endfunction

  assign txData = localPat(popTot - popBase);
  assign pIdx   = pRxTot - pBase;
  assign curOut = (pIdx == 0) ? {pcT, plT[10:8]} :
                  (pIdx == 1) ? plT[7:0] :
                  ((pIdx - 2) < int'(plT)) ? peerPat(pIdx - 2) : 8'h00;
  assign miso   = curOut[3'(7 - pBit)];

  frame_link_master uut (
    .clk(clk), .rstN(rstN), .enable(enable), .ctsIn(ctsIn), .rtsIn(rtsIn),
    .sendValid(sendValid), .sendCmd(sendCmd), .sendLen(sendLen), .sendAck(sendAck),
    .txData(txData), .txPop(txPop), .rxCmd(rxCmd), .rxLen(rxLen),
    .rxHdrValid(rxHdrValid), .rxData(rxData), .rxValid(rxValid), .done(done),
    .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN)
  );

  // peer: sample on rising sclk, advance on falling sclk
  always @(negedge csN) pBase = pRxTot;
  always @(posedge sclk) if (!csN) pShift = {pShift[6:0], mosi};
  always @(negedge sclk) begin
    if (!csN) begin
      if (pBit == 7) begin
        if (pIdx < 64) peerRx[pIdx] = pShift;
        pRxTot = pRxTot + 1;
        pBit = 0;
      end else begin
        pBit = pBit + 1;
      end
    end
  end

  always @(posedge clk) if (txPop) popTot <= popTot + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (done) doneTot++;
      if (csPrev && !csN) csFallTot++;
      if (!csPrev && csN) csRiseTot++;
      csPrev = csN;
      if (rxHdrValid) begin
        hdrTot++;
        lastCmd = rxCmd;
        lastLen = rxLen;
      end
      if (rxValid) begin
        if ((rxTot - rxBase) < 64) rxGot[rxTot - rxBase] = rxData;
        rxTot++;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", passCnt, checkCnt + 1);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checkCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
  endtask

  task automatic pulseCts();
    ctsIn = 1'b1;
    repeat (3) tick();
    ctsIn = 1'b0;
    repeat (2) tick();
  endtask

  task automatic waitDone(input int bDone, input int bFall);
    int n;
    n = 0;
    while (doneTot == bDone && n < 6000) begin
      tick();
      if (csFallTot != bFall) sendValid = 1'b0;
      n++;
    end
  endtask

  task automatic runTx(input logic [4:0] lc, input int ll, input logic [4:0] pc, input int pl,
                       input bit poll, input bit rtsFirst);
    int bDone, bRise, bHdr, bFall, tot, epl, ol, bad, k;
    logic [4:0] oc, epc;
    bit force0;
    tick();
    pcT = pc; plT = 11'(pl);
    bDone = doneTot; bRise = csRiseTot; bHdr = hdrTot; bFall = csFallTot;
    rxBase = rxTot; popBase = popTot;
    if (poll || rtsFirst) begin rtsIn = 1'b1; repeat (6) tick(); end
    if (!poll) begin sendCmd = lc; sendLen = 11'(ll); sendValid = 1'b1; end
    pulseCts();
    waitDone(bDone, bFall);
    sendValid = 1'b0;
    rtsIn = 1'b0;
    repeat (4) tick();
    oc = poll ? 5'd0 : lc;
    ol = poll ? 0 : ll;
    force0 = oc[4];
    epc = force0 ? 5'd0 : pc;
    epl = force0 ? 0 : pl;
    tot = padRef((ol > epl) ? ol : epl);
    chk(peerRx[0] == {oc, 3'(ol >> 8)} && peerRx[1] == 8'(ol), poll ? "R7" : "R1",
        "header bytes seen by peer", {peerRx[0], peerRx[1]}, {oc, 3'(ol >> 8), 8'(ol)});
    chk(pIdx == tot + 2, "R3 R4", "bytes in transaction", pIdx, tot + 2);
    bad = 0;
    for (k = 0; k < tot && k + 2 < 64; k++)
      if (peerRx[k + 2] != ((k < ol) ? localPat(k) : 8'h00)) bad++;
    chk(bad == 0, "R10", "payload/zero fill mismatches", bad, 0);
    chk(popTot - popBase == ol, "R10", "txPop count", popTot - popBase, ol);
    if (epc != 0)
      chk(hdrTot - bHdr == 1 && lastCmd == epc && lastLen == 11'(epl), force0 ? "R11" : "R2",
          "decoded peer header", int'(lastCmd) * 4096 + int'(lastLen), int'(epc) * 4096 + epl);
    else
      chk(hdrTot - bHdr == 0, force0 ? "R11" : "R8", "rxHdrValid pulses", hdrTot - bHdr, 0);
    bad = 0;
    for (k = 0; k < epl && k < 64; k++) if (rxGot[k] != peerPat(k)) bad++;
    chk(rxTot - rxBase == ((epc != 0) ? epl : 0) && (epc == 0 || bad == 0), "R8 R10",
        "received payload bytes", rxTot - rxBase, (epc != 0) ? epl : 0);
    chk(doneTot - bDone == 1 && csRiseTot - bRise == 1, "R5", "done and csN release",
        doneTot - bDone, 1);
  endtask

  initial begin
    int bD, bF, bH;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk(csN == 1'b1 && sclk == 1'b0 && done == 1'b0, "R5 R9", "idle after reset",
        {csN, sclk, done}, 3'b100);
    chk(rxValid == 1'b0 && rxHdrValid == 1'b0 && txPop == 1'b0, "R2", "quiet after reset",
        {rxValid, rxHdrValid, txPop}, 0);

    // R6: disabled block does not start, then honours the latched edge
    pcT = 5'd0; plT = 11'd0; popBase = popTot;
    sendCmd = 5'd3; sendLen = 11'd4; sendValid = 1'b1;
    bF = csFallTot; bD = doneTot;
    pulseCts();
    repeat (300) tick();
    chk(csFallTot == bF, "R6", "start while disabled", csFallTot - bF, 0);
    enable = 1'b1;
    waitDone(bD, bF);
    chk(doneTot == bD + 1, "R6", "latched CTS used once enabled", doneTot - bD, 1);
    // R6: without a fresh CTS edge nothing starts
    sendValid = 1'b1; bF = csFallTot; bD = doneTot;
    repeat (400) tick();
    chk(csFallTot == bF, "R6", "start without new CTS edge", csFallTot - bF, 0);
    pulseCts();
    waitDone(bD, bF);
    sendValid = 1'b0;
    chk(doneTot == bD + 1, "R6", "start after new CTS edge", doneTot - bD, 1);
    repeat (4) tick();

    // sweep of local/peer lengths and commands (R1-R5, R8, R10, R11)
    for (int i = 0; i < 10; i++) begin
      for (int j = 0; j < 10; j++) begin
        int li, lj;
        li = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 3 : (i == 3) ? 4 : (i == 4) ? 5 :
             (i == 5) ? 6 : (i == 6) ? 7 : (i == 7) ? 10 : (i == 8) ? 13 : 30;
        lj = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 3 : (j == 3) ? 4 : (j == 4) ? 5 :
             (j == 5) ? 6 : (j == 6) ? 7 : (j == 7) ? 10 : (j == 8) ? 13 : 30;
        runTx(5'((i * 5 + j * 11) % 31 + 1), li, ((i + j) % 4 == 0) ? 5'd0 : 5'((i * 7 + j * 3) % 31 + 1),
              lj, 1'b0, 1'b0);
      end
    end

    // R7: poll transactions
    runTx(5'd0, 0, 5'd5, 7, 1'b1, 1'b0);
    runTx(5'd0, 0, 5'd9, 0, 1'b1, 1'b0);
    // R13: send wins over a poll when both are possible
    runTx(5'd2, 3, 5'd4, 2, 1'b0, 1'b1);
    chk(peerRx[0] == 8'h10, "R13", "send chosen over poll", peerRx[0], 8'h10);

    // R12: link reset on RTS rising edge while armed
    pcT = 5'd6; plT = 11'd3;
    bD = doneTot; bF = csFallTot; bH = hdrTot;
    pulseCts();
    repeat (10) tick();
    rtsIn = 1'b1;
    waitDone(bD, bF);
    repeat (4) tick();
    chk(pIdx == 1 && peerRx[0] == 8'h00, "R12", "link reset byte count", pIdx, 1);
    chk(doneTot - bD == 1 && hdrTot == bH, "R12", "link reset done without header",
        doneTot - bD, 1);
    rtsIn = 1'b0;
    repeat (6) tick();

    $display("%0d/%0d checks passed", passCnt, checkCnt);
    $finish;
  end

endmodule